// File: doc/BRIEF.md
# Two-Bit Burst Address Sequencer

This block produces the two low-order address bits for four-beat bursts of a synchronous memory. A burst starts when an address strobe captures the low address bits presented at the clock edge. Each later edge with the advance input low moves the burst to the next beat. The upper address bits are registered elsewhere and are joined with this block's two-bit offset to form the full word address.

There are two active-low strobes, one for a processor and one for a controller. The processor strobe has priority, but it counts only while the active-low first chip enable is low. A mode input selects the beat order. In linear order the offset counts upward and wraps inside its aligned group of four. In interleaved order the start offset is XORed with the beat number. A registered flag records which strobe began the current burst, so that downstream write and cycle-qualification logic can tell the two burst kinds apart.

Top module: `burst_addr_seq`

## Requirements
- R1: After reset, `offset_o` is 0 in both orders and `proc_start_o` is 0.
- R2: A strobe that is recognised at a clock edge copies `addr_lo_i` into the start register and restarts the beat count at 0. After that edge `offset_o` equals the captured bits in either order.
- R3: When both strobes are low and `ce1_n_i` is low, the processor strobe is the one acted on, and `proc_start_o` reads 1 after the edge.
- R4: While `ce1_n_i` is high, the processor strobe has no effect. The controller strobe can still load, and then `proc_start_o` reads 0. If the controller strobe is also high, no load happens.
- R5: At an edge with no recognised strobe and `adv_n_i` low, the beat count increments by one, modulo 4.
- R6: At an edge with no recognised strobe and `adv_n_i` high, the start, the beat count and `proc_start_o` all keep their values.
- R7: With `lin_mode_i` = 1 (linear order), `offset_o` = (start + beat) mod 4.
- R8: With `lin_mode_i` = 0 (interleaved order), `offset_o` = start XOR beat. For a start of 1 this gives the sequence 1, 0, 3, 2.
- R9: The offset stays inside its aligned group of four. After four advances it is back at the start offset.
- R10: `proc_start_o` is 1 when the most recent load came from the processor strobe and 0 when it came from the controller strobe. Advancing and holding leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_lo_i | input | 2 | Low address bits captured on a load |
| ads_proc_n_i | input | 1 | Processor address strobe, active low |
| ads_ctrl_n_i | input | 1 | Controller address strobe, active low |
| ce1_n_i | input | 1 | First chip enable, active low; gates the processor strobe |
| adv_n_i | input | 1 | Advance, active low |
| lin_mode_i | input | 1 | 1 selects linear order, 0 selects interleaved order |
| offset_o | output | 2 | Current burst offset |
| proc_start_o | output | 1 | 1 when the current burst was started by the processor strobe |

## Verification
`offset_o` is combinational in `lin_mode_i`. For that reason the hold and linear-step properties accept the old offset only when the mode pin was the same on the sampled edge and the edge after it. This assumes the order is a static strap between bursts. The stimulus in the directed phases keeps the mode fixed for the whole of each burst. The random phase changes the mode only at the first cycle of a segment. The reference model still evaluates every cycle against the current mode, so mid-burst mode flips are also covered by the bench comparison.

// File: rtl/bsq_pkg.sv
package bsq_pkg;
    localparam int unsigned OFS_W = 2;
    typedef logic [OFS_W-1:0] ofs_t;

    typedef struct packed {
        ofs_t start;
        ofs_t beat;
        logic by_proc;
    } bsq_state_t;
endpackage

// File: rtl/bsq_load_arb.sv
module bsq_load_arb (
    input  logic ads_proc_n_i,
    input  logic ads_ctrl_n_i,
    input  logic ce1_n_i,
    output logic load_o,
    output logic from_proc_o
);
    logic proc_ok;
    logic ctrl_ok;

    always_comb begin
        proc_ok     = !ads_proc_n_i && !ce1_n_i;
        ctrl_ok     = !ads_ctrl_n_i && !proc_ok;
        load_o      = proc_ok || ctrl_ok;
        from_proc_o = proc_ok;
    end
endmodule

// File: rtl/bsq_order_map.sv
module bsq_order_map #(
    parameter int unsigned W = 2
) (
    input  logic [W-1:0] start_i,
    input  logic [W-1:0] beat_i,
    input  logic         lin_i,
    output logic [W-1:0] ofs_o
);
    logic [W-1:0] ilv;
    logic [W-1:0] lin_sum;

    for (genvar b = 0; b < W; b++) begin : g_ilv
        assign ilv[b] = start_i[b] ^ beat_i[b];
    end

    always_comb begin
        lin_sum = start_i + beat_i;
        ofs_o   = lin_i ? lin_sum : ilv;
    end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import bsq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] addr_lo_i,
    input  logic       ads_proc_n_i,
    input  logic       ads_ctrl_n_i,
    input  logic       ce1_n_i,
    input  logic       adv_n_i,
    input  logic       lin_mode_i,
    output logic [1:0] offset_o,
    output logic       proc_start_o
);
    bsq_state_t st_d;
    bsq_state_t st_q;
    logic       load;
    logic       from_proc;

    bsq_load_arb arb_i (
        .ads_proc_n_i (ads_proc_n_i),
        .ads_ctrl_n_i (ads_ctrl_n_i),
        .ce1_n_i      (ce1_n_i),
        .load_o       (load),
        .from_proc_o  (from_proc)
    );

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.start   = addr_lo_i;
            st_d.beat    = '0;
            st_d.by_proc = from_proc;
        end else if (!adv_n_i) begin
            st_d.beat = st_q.beat + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    bsq_order_map #(.W(OFS_W)) map_i (
        .start_i (st_q.start),
        .beat_i  (st_q.beat),
        .lin_i   (lin_mode_i),
        .ofs_o   (offset_o)
    );

    assign proc_start_o = st_q.by_proc;
endmodule

// File: rtl/bsq_checker.sv
module bsq_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] addr_lo_i,
    input logic       ads_proc_n_i,
    input logic       ads_ctrl_n_i,
    input logic       ce1_n_i,
    input logic       adv_n_i,
    input logic       lin_mode_i,
    input logic [1:0] offset_o,
    input logic       proc_start_o
);
    logic p_rec;
    logic any_rec;
    assign p_rec   = !ads_proc_n_i && !ce1_n_i;
    assign any_rec = p_rec || !ads_ctrl_n_i;

    // R2: offset after a load equals the captured bits
    p_load_value_r2: assert property (@(posedge clk) disable iff (!rst_n)
        any_rec |=> offset_o == $past(addr_lo_i));

    // R3: processor wins when both strobes are low and enabled
    p_proc_priority_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (p_rec && !ads_ctrl_n_i) |=> proc_start_o);

    // R4: disabled processor strobe lets the controller strobe load
    p_ce_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ce1_n_i && !ads_ctrl_n_i) |=> !proc_start_o);

    // R6: hold when idle and mode unchanged
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!any_rec && adv_n_i) |=>
        ((lin_mode_i != $past(lin_mode_i)) ||
         (offset_o == $past(offset_o) && proc_start_o == $past(proc_start_o))));

    // R7: linear step adds one modulo 4
    p_lin_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!any_rec && !adv_n_i && lin_mode_i) |=>
        (!lin_mode_i || offset_o == 2'($past(offset_o) + 2'd1)));

    // R10: advancing keeps the load source flag
    p_src_kept_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !any_rec |=> $stable(proc_start_o));
endmodule

bind burst_addr_seq bsq_checker chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .addr_lo_i    (addr_lo_i),
    .ads_proc_n_i (ads_proc_n_i),
    .ads_ctrl_n_i (ads_ctrl_n_i),
    .ce1_n_i      (ce1_n_i),
    .adv_n_i      (adv_n_i),
    .lin_mode_i   (lin_mode_i),
    .offset_o     (offset_o),
    .proc_start_o (proc_start_o)
);

// File: tb/burst_addr_seq_tb_top.sv
module burst_addr_seq_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] addr_lo_i = 2'd0;
    logic       ads_proc_n_i = 1'b1;
    logic       ads_ctrl_n_i = 1'b1;
    logic       ce1_n_i = 1'b1;
    logic       adv_n_i = 1'b1;
    logic       lin_mode_i = 1'b1;
    logic [1:0] offset_o;
    logic       proc_start_o;

    int total = 0;
    int bad = 0;
    int m_start = 0;
    int m_beat = 0;
    int m_proc = 0;
    bit done = 0;

    always #2 clk = ~clk;

    burst_addr_seq dut_i (
        .clk (clk), .rst_n (rst_n), .addr_lo_i (addr_lo_i),
        .ads_proc_n_i (ads_proc_n_i), .ads_ctrl_n_i (ads_ctrl_n_i),
        .ce1_n_i (ce1_n_i), .adv_n_i (adv_n_i), .lin_mode_i (lin_mode_i),
        .offset_o (offset_o), .proc_start_o (proc_start_o)
    );

    function automatic int exp_ofs();
        if (lin_mode_i) return (m_start + m_beat) % 4;
        return m_start ^ m_beat;
    endfunction

    task automatic check(input string req);
        int e = exp_ofs();
        total++;
        if (offset_o !== 2'(e) || proc_start_o !== 1'(m_proc)) begin
            bad++;
            $display("FAIL %s: offset=%0d proc=%0d expected offset=%0d proc=%0d",
                     req, offset_o, proc_start_o, e, m_proc);
        end
    endtask

    task automatic cyc(input bit p_n, input bit c_n, input bit ce_n,
                       input bit adv_n, input int a, input bit lin, input string req);
        bit lp;
        addr_lo_i = 2'(a); ads_proc_n_i = p_n; ads_ctrl_n_i = c_n;
        ce1_n_i = ce_n; adv_n_i = adv_n; lin_mode_i = lin;
        @(posedge clk);
        lp = !p_n && !ce_n;
        if (lp || !c_n) begin
            m_start = a; m_beat = 0; m_proc = lp ? 1 : 0;
        end else if (!adv_n) begin
            m_beat = (m_beat + 1) % 4;
        end
        @(negedge clk);
        check(req);
    endtask

    initial begin
        #200000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: run did not complete");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset linear");
        lin_mode_i = 1'b0; #0;
        check("R1 reset interleaved");
        rst_n = 1'b1;
        @(negedge clk);
        // linear bursts from each start, with wrap
        for (int s = 0; s < 4; s++) begin
            cyc(1, 0, 1, 1, s, 1, "R2 ctrl load");
            for (int k = 0; k < 4; k++) cyc(1, 1, 1, 0, 3 - s, 1, "R7 R5 R9 linear");
            cyc(1, 1, 1, 1, 0, 1, "R6 hold");
        end
        // interleaved bursts
        for (int s = 0; s < 4; s++) begin
            cyc(0, 1, 0, 1, s, 0, "R2 proc load");
            for (int k = 0; k < 4; k++) cyc(1, 1, 0, 0, 0, 0, "R8 R5 R9 interleaved");
        end
        cyc(0, 0, 0, 1, 2, 0, "R3 both strobes");
        cyc(1, 1, 0, 0, 1, 0, "R10 flag kept on advance");
        cyc(0, 1, 1, 0, 3, 0, "R4 proc gated, advance");
        cyc(0, 1, 1, 1, 0, 0, "R4 proc gated, hold");
        cyc(0, 0, 1, 1, 1, 1, "R4 ctrl loads when proc gated");
        cyc(1, 0, 0, 0, 3, 1, "R10 ctrl load clears flag");
        cyc(1, 1, 0, 1, 0, 1, "R6 hold flag");
        for (int i = 0; i < 600; i++) begin
            int r = $urandom;
            cyc(r[0] | r[1], r[2] | r[3], r[4], r[5], int'(r[7:6]),
                (i % 8 == 0) ? r[8] : lin_mode_i, "R2 R5 R7 R8 random");
        end
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule